// File: doc/BRIEF.md
# Clock-Decoupled Memory Command Bridge

This block connects user logic running on its own clock to the command port of a memory controller clocked at 200 MHz. The user side gets a simple split-phase interface. A command carries an address, a read/write flag, a half-burst flag, a 32-bit tag, two write beats and their byte masks. The bridge acknowledges the command at once. Read results come back later as a held beat with a valid flag and the tag of the read that produced it. The user pops each beat with a one-cycle acknowledge.

Commands cross into the controller domain through a dual-clock queue. The two sides of that queue exchange pointers as gray codes through two-flop synchronisers. On the controller side, an issuer presents each command while the controller shows ready. Write beats wait in a local queue until the controller asks for them. A tag queue pairs each outstanding read with the beats that come back for it. Returned beats cross back to the user domain through a second dual-clock queue. Commands are never reordered.

A read is issued only when the return queue is certain to have room for all of its beats. The return queue therefore never overflows, even if the user stops popping.

Top module: `memCmdBridge`

## Requirements
- R1: `usrCmdAck` is high in exactly those user cycles in which `usrCmdValid` is high and the command queue is not full. This can be the first cycle of valid. When the controller makes no progress, exactly `2**CMD_AW` commands are accepted before the acknowledge is withheld.
- R2: Commands reach the controller side in the order in which they were acknowledged, and each keeps its read/write flag and half-burst flag.
- R3: `ctlRead` or `ctlWrite` is raised only in a cycle where `ctlReady` is high, and never both together. The controller accepts a command on a rising edge that sees ready and one of the two command lines.
- R4: `ctlAddr` equals the user address with bits [3:0] forced to zero. Bits [31:4] pass through unchanged.
- R5: A write with half-burst set supplies one beat, which is the low 144 bits of `usrWrData` with the low 18 bits of `usrWrMask`. A write with half-burst clear supplies that beat and then the high beat with the high mask. Each beat is presented on `ctlWrData`/`ctlWrMask` in a cycle where `ctlGetData` is high, and it advances on that edge.
- R6: On each edge where `ctlDataValid` is high, the bridge captures `ctlRdData`. The user sees the captured beats in order, each paired with the 32-bit tag of the read it belongs to. A half-burst read returns one beat and a full read returns two.
- R7: While `usrRdValid` is high and `usrRdAck` is low, `usrRdData` and `usrRdTag` stay unchanged. A one-cycle acknowledge pops exactly one beat.
- R8: A read is issued only when the return queue has room for its beats and for every beat still outstanding. No returned beat is lost when the user stops popping.
- R9: After reset, `usrRdValid`, `ctlRead` and `ctlWrite` are low, and `usrCmdAck` is low while `usrCmdValid` is low.
- R10: Every acknowledged command is issued to the controller exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usrClk | input | 1 | User-domain clock |
| usrRstN | input | 1 | User-domain reset, active low |
| ctlClk | input | 1 | Controller-domain clock |
| ctlRstN | input | 1 | Controller-domain reset, active low |
| usrCmdValid | input | 1 | Command present |
| usrCmdWrite | input | 1 | 1 = write, 0 = read |
| usrCmdHalf | input | 1 | 1 = one data beat, 0 = two beats |
| usrCmdAddr | input | ADDR_W | Byte address; bits [3:0] ignored |
| usrCmdTag | input | TAG_W | Tag returned with each beat of a read |
| usrWrData | input | 2*BEAT_W | Write beats; low half is the first beat |
| usrWrMask | input | 2*BEAT_W/8 | Byte enables; low half goes with the first beat |
| usrCmdAck | output | 1 | Command taken this cycle |
| usrRdValid | output | 1 | Read beat held on the outputs |
| usrRdData | output | BEAT_W | Read beat |
| usrRdTag | output | TAG_W | Tag of the read that produced the beat |
| usrRdAck | input | 1 | Pops the held beat |
| ctlReady | input | 1 | Controller can take a command |
| ctlRead | output | 1 | Issue a read |
| ctlWrite | output | 1 | Issue a write |
| ctlHalf | output | 1 | Half-burst flag of the issued command |
| ctlAddr | output | ADDR_W | Aligned address of the issued command |
| ctlGetData | input | 1 | Controller takes one write beat |
| ctlWrData | output | BEAT_W | Current write beat |
| ctlWrMask | output | BEAT_W/8 | Byte enables of the current write beat |
| ctlDataValid | input | 1 | Controller returns one read beat |
| ctlRdData | input | BEAT_W | Returned read beat |

## Verification
The bench mixes reads and writes with random half-burst flags, unaligned addresses, random ready gaps and random data-phase delays. This checks ordering, address alignment, the beat count and beat order of each write, and the pairing of tags with returned beats. Holding the controller's ready low while the user keeps pushing shows whether the acknowledge is withheld at exactly the queue depth, rather than one entry early or late. A run of full-burst reads while the user pops nothing carries more return beats than the return queue can hold. It tells a bridge that throttles reads correctly from one that drops or overwrites beats. Directed single commands on an idle bridge confirm the same-cycle acknowledge, and show that a half burst moves one beat where a full burst moves two.

// File: rtl/memBridgePkg.sv
package memBridgePkg;

  // Strobes from the controller-side issuer to the datapath
  typedef struct packed {
    logic cmdPop;     // head command issued to the controller
    logic wrPush;     // park the write beats of the issued command
    logic wrPop;      // last beat of the head write taken
    logic wrBeatSel;  // 0 = first beat, 1 = second beat
    logic tagPush;    // remember tag of the issued read
    logic tagPop;     // last beat of the oldest read returned
    logic rdPush;     // capture one returned beat
  } bridgeStrobes_t;

endpackage

// File: rtl/asyncFifo.sv
module asyncFifo #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             wClk,
  input  logic             wRstN,
  input  logic             wPush,
  input  logic [WIDTH-1:0] wData,
  output logic             wFull,
  output logic [AW:0]      wLevel,
  input  logic             rClk,
  input  logic             rRstN,
  input  logic             rPop,
  output logic [WIDTH-1:0] rData,
  output logic             rEmpty
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wBin, wGray, wBinNext;
  logic [AW:0] rBin, rGray, rBinNext;
  logic [AW:0] rSync1, rSync2, wSync1, wSync2;

  function automatic logic [AW:0] toGray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] toBin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign wBinNext = wBin + {{AW{1'b0}}, wPush};

  always_ff @(posedge wClk or negedge wRstN) begin
    if (!wRstN) begin
      wBin   <= '0;
      wGray  <= '0;
      rSync1 <= '0;
      rSync2 <= '0;
    end else begin
      wBin   <= wBinNext;
      wGray  <= toGray(wBinNext);
      rSync1 <= rGray;
      rSync2 <= rSync1;
    end
  end

  always_ff @(posedge wClk) begin
    if (wPush) mem[wBin[AW-1:0]] <= wData;
  end

  assign wFull  = (wGray == {~rSync2[AW:AW-1], rSync2[AW-2:0]});
  assign wLevel = wBin - toBin(rSync2);

  // read domain
  assign rBinNext = rBin + {{AW{1'b0}}, rPop};

  always_ff @(posedge rClk or negedge rRstN) begin
    if (!rRstN) begin
      rBin   <= '0;
      rGray  <= '0;
      wSync1 <= '0;
      wSync2 <= '0;
    end else begin
      rBin   <= rBinNext;
      rGray  <= toGray(rBinNext);
      wSync1 <= wGray;
      wSync2 <= wSync1;
    end
  end

  assign rEmpty = (rGray == wSync2);
  assign rData  = mem[rBin[AW-1:0]];

  // R1 R8
  no_overflow_chk: assert property (@(posedge wClk) disable iff (!wRstN)
    wPush |-> !wFull);

  // R7
  no_underflow_chk: assert property (@(posedge rClk) disable iff (!rRstN)
    rPop |-> !rEmpty);

endmodule

// File: rtl/syncFifo.sv
module syncFifo #(
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic [AW:0]      count
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wPtr, rPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      wPtr  <= wPtr + {{(AW-1){1'b0}}, push};
      rPtr  <= rPtr + {{(AW-1){1'b0}}, pop};
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wPtr] <= pushData;
  end

  assign popData = mem[rPtr];
  assign empty   = (count == '0);

  // R5 R6
  q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop |-> count != CAP);

  // R5 R6
  q_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import memBridgePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 144,
  parameter int TAG_W  = 32,
  parameter int CMD_AW = 3,
  parameter int RD_AW  = 4,
  parameter int OUT_AW = 2
) (
  input  logic                  usrClk,
  input  logic                  usrRstN,
  input  logic                  ctlClk,
  input  logic                  ctlRstN,
  input  logic                  usrCmdValid,
  input  logic                  usrCmdWrite,
  input  logic                  usrCmdHalf,
  input  logic [ADDR_W-1:0]     usrCmdAddr,
  input  logic [TAG_W-1:0]      usrCmdTag,
  input  logic [2*BEAT_W-1:0]   usrWrData,
  input  logic [2*BEAT_W/8-1:0] usrWrMask,
  output logic                  usrCmdAck,
  output logic                  usrRdValid,
  output logic [BEAT_W-1:0]     usrRdData,
  output logic [TAG_W-1:0]      usrRdTag,
  input  logic                  usrRdAck,
  output logic                  ctlHalf,
  output logic [ADDR_W-1:0]     ctlAddr,
  output logic [BEAT_W-1:0]     ctlWrData,
  output logic [BEAT_W/8-1:0]   ctlWrMask,
  input  logic [BEAT_W-1:0]     ctlRdData,
  input  bridgeStrobes_t        stb,
  output logic                  headValid,
  output logic                  headWrite,
  output logic                  headHalf,
  output logic                  wrHeadHalf,
  output logic                  tagHeadHalf,
  output logic [OUT_AW:0]       wrCount,
  output logic [OUT_AW:0]       tagCount,
  output logic [RD_AW:0]        rdLevel,
  output logic                  rdFull
);
  localparam int MASK_W = BEAT_W / 8;
  localparam int PAIR_W = 2 * BEAT_W + 2 * MASK_W;
  localparam int CMD_W  = 2 + (ADDR_W - 4) + TAG_W + PAIR_W;
  localparam int WRQ_W  = 1 + PAIR_W;
  localparam int TAGQ_W = 1 + TAG_W;
  localparam int RET_W  = BEAT_W + TAG_W;

  logic [CMD_W-1:0]    cmdIn, cmdOut;
  logic                cmdFull, cmdEmpty;
  logic [CMD_AW:0]     cmdLevelUnused;
  logic [ADDR_W-5:0]   hAddr;
  logic [TAG_W-1:0]    hTag;
  logic [PAIR_W-1:0]   hPair;
  logic [WRQ_W-1:0]    wrOut;
  logic [PAIR_W-1:0]   qPair;
  logic [2*BEAT_W-1:0] qData;
  logic [2*MASK_W-1:0] qMask;
  logic [TAGQ_W-1:0]   tagOut;
  logic [TAG_W-1:0]    tagHead;
  logic                wrEmptyUnused, tagEmptyUnused, rdEmpty;
  logic                unusedAddrLow;

  // user side: accept while the command queue has room
  assign usrCmdAck     = usrCmdValid & ~cmdFull;
  assign cmdIn         = {usrCmdWrite, usrCmdHalf, usrCmdAddr[ADDR_W-1:4], usrCmdTag, usrWrData, usrWrMask};
  assign unusedAddrLow = ^usrCmdAddr[3:0];

  asyncFifo #(.WIDTH(CMD_W), .AW(CMD_AW)) u_cmdQ (
    .wClk(usrClk), .wRstN(usrRstN), .wPush(usrCmdAck), .wData(cmdIn),
    .wFull(cmdFull), .wLevel(cmdLevelUnused),
    .rClk(ctlClk), .rRstN(ctlRstN), .rPop(stb.cmdPop), .rData(cmdOut),
    .rEmpty(cmdEmpty)
  );

  assign {headWrite, headHalf, hAddr, hTag, hPair} = cmdOut;
  assign headValid = ~cmdEmpty;
  assign ctlAddr   = {hAddr, 4'b0000};
  assign ctlHalf   = headHalf;

  // write beats parked until the controller asks for them
  syncFifo #(.WIDTH(WRQ_W), .AW(OUT_AW)) u_wrQ (
    .clk(ctlClk), .rstN(ctlRstN), .push(stb.wrPush), .pushData({headHalf, hPair}),
    .pop(stb.wrPop), .popData(wrOut), .empty(wrEmptyUnused), .count(wrCount)
  );

  assign {wrHeadHalf, qPair} = wrOut;
  assign {qData, qMask}      = qPair;
  assign ctlWrData = stb.wrBeatSel ? qData[2*BEAT_W-1:BEAT_W] : qData[BEAT_W-1:0];
  assign ctlWrMask = stb.wrBeatSel ? qMask[2*MASK_W-1:MASK_W] : qMask[MASK_W-1:0];

  // tags of reads in flight
  syncFifo #(.WIDTH(TAGQ_W), .AW(OUT_AW)) u_tagQ (
    .clk(ctlClk), .rstN(ctlRstN), .push(stb.tagPush), .pushData({headHalf, hTag}),
    .pop(stb.tagPop), .popData(tagOut), .empty(tagEmptyUnused), .count(tagCount)
  );

  assign {tagHeadHalf, tagHead} = tagOut;

  // returned beats back to the user domain
  asyncFifo #(.WIDTH(RET_W), .AW(RD_AW)) u_retQ (
    .wClk(ctlClk), .wRstN(ctlRstN), .wPush(stb.rdPush), .wData({ctlRdData, tagHead}),
    .wFull(rdFull), .wLevel(rdLevel),
    .rClk(usrClk), .rRstN(usrRstN), .rPop(usrRdAck & ~rdEmpty), .rData({usrRdData, usrRdTag}),
    .rEmpty(rdEmpty)
  );

  assign usrRdValid = ~rdEmpty;

  // R7
  rd_hold_chk: assert property (@(posedge usrClk) disable iff (!usrRstN)
    usrRdValid && !usrRdAck |=> usrRdValid && $stable(usrRdData) && $stable(usrRdTag));

endmodule

// File: rtl/bridgeControl.sv
module bridgeControl
  import memBridgePkg::*;
#(
  parameter int RD_AW  = 4,
  parameter int OUT_AW = 2
) (
  input  logic            ctlClk,
  input  logic            ctlRstN,
  input  logic            ctlReady,
  input  logic            ctlGetData,
  input  logic            ctlDataValid,
  input  logic            headValid,
  input  logic            headWrite,
  input  logic            headHalf,
  input  logic            wrHeadHalf,
  input  logic            tagHeadHalf,
  input  logic [OUT_AW:0] wrCount,
  input  logic [OUT_AW:0] tagCount,
  input  logic [RD_AW:0]  rdLevel,
  input  logic            rdFull,
  output logic            ctlRead,
  output logic            ctlWrite,
  output bridgeStrobes_t  stb
);
  localparam int PW = RD_AW + 2;
  localparam logic [PW-1:0]   RD_CAP  = PW'(1) << RD_AW;
  localparam logic [OUT_AW:0] OUT_CAP = {1'b1, {OUT_AW{1'b0}}};

  logic [PW-1:0] pendBeats, needBeats, rdFree;
  logic rdRoom, canIssue, wrBeat, rdBeat, wrLast, rdLast;

  assign needBeats = headHalf ? PW'(1) : PW'(2);
  assign rdFree    = RD_CAP - {1'b0, rdLevel};
  assign rdRoom    = (pendBeats + needBeats) <= rdFree;
  assign canIssue  = headValid & ctlReady &
                     (headWrite ? (wrCount != OUT_CAP) : ((tagCount != OUT_CAP) & rdRoom));
  assign ctlWrite  = canIssue & headWrite;
  assign ctlRead   = canIssue & ~headWrite;

  assign wrLast = wrHeadHalf | wrBeat;
  assign rdLast = tagHeadHalf | rdBeat;

  always_comb begin
    stb           = '0;
    stb.cmdPop    = canIssue;
    stb.wrPush    = ctlWrite;
    stb.tagPush   = ctlRead;
    stb.wrPop     = ctlGetData & wrLast;
    stb.wrBeatSel = wrBeat;
    stb.rdPush    = ctlDataValid;
    stb.tagPop    = ctlDataValid & rdLast;
  end

  always_ff @(posedge ctlClk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      wrBeat    <= 1'b0;
      rdBeat    <= 1'b0;
      pendBeats <= '0;
    end else begin
      if (ctlGetData) wrBeat <= ~wrLast;
      if (ctlDataValid) rdBeat <= ~rdLast;
      pendBeats <= pendBeats + (ctlRead ? needBeats : '0) - (ctlDataValid ? PW'(1) : '0);
    end
  end

  // R5
  getdata_has_beat_chk: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
    ctlGetData |-> wrCount != '0);

  // R6
  tag_pairing_chk: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
    ctlDataValid |-> tagCount != '0);

  // R8
  ret_room_chk: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
    ctlDataValid |-> !rdFull);

  // R3
  ready_gap_chk: assert property (@(posedge ctlClk) disable iff (!ctlRstN)
    (ctlRead || ctlWrite) |-> !(ctlRead && ctlWrite));

endmodule

// File: rtl/memCmdBridge.sv
module memCmdBridge
  import memBridgePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 144,
  parameter int TAG_W  = 32,
  parameter int CMD_AW = 3,
  parameter int RD_AW  = 4,
  parameter int OUT_AW = 2
) (
  input  logic                  usrClk,
  input  logic                  usrRstN,
  input  logic                  ctlClk,
  input  logic                  ctlRstN,
  input  logic                  usrCmdValid,
  input  logic                  usrCmdWrite,
  input  logic                  usrCmdHalf,
  input  logic [ADDR_W-1:0]     usrCmdAddr,
  input  logic [TAG_W-1:0]      usrCmdTag,
  input  logic [2*BEAT_W-1:0]   usrWrData,
  input  logic [2*BEAT_W/8-1:0] usrWrMask,
  output logic                  usrCmdAck,
  output logic                  usrRdValid,
  output logic [BEAT_W-1:0]     usrRdData,
  output logic [TAG_W-1:0]      usrRdTag,
  input  logic                  usrRdAck,
  input  logic                  ctlReady,
  output logic                  ctlRead,
  output logic                  ctlWrite,
  output logic                  ctlHalf,
  output logic [ADDR_W-1:0]     ctlAddr,
  input  logic                  ctlGetData,
  output logic [BEAT_W-1:0]     ctlWrData,
  output logic [BEAT_W/8-1:0]   ctlWrMask,
  input  logic                  ctlDataValid,
  input  logic [BEAT_W-1:0]     ctlRdData
);
  bridgeStrobes_t  stb;
  logic            headValid, headWrite, headHalf, wrHeadHalf, tagHeadHalf, rdFull;
  logic [OUT_AW:0] wrCount, tagCount;
  logic [RD_AW:0]  rdLevel;

  bridgeDatapath #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .TAG_W(TAG_W),
    .CMD_AW(CMD_AW), .RD_AW(RD_AW), .OUT_AW(OUT_AW)
  ) u_datapath (
    .usrClk(usrClk), .usrRstN(usrRstN), .ctlClk(ctlClk), .ctlRstN(ctlRstN),
    .usrCmdValid(usrCmdValid), .usrCmdWrite(usrCmdWrite), .usrCmdHalf(usrCmdHalf),
    .usrCmdAddr(usrCmdAddr), .usrCmdTag(usrCmdTag), .usrWrData(usrWrData),
    .usrWrMask(usrWrMask), .usrCmdAck(usrCmdAck),
    .usrRdValid(usrRdValid), .usrRdData(usrRdData), .usrRdTag(usrRdTag), .usrRdAck(usrRdAck),
    .ctlHalf(ctlHalf), .ctlAddr(ctlAddr), .ctlWrData(ctlWrData), .ctlWrMask(ctlWrMask),
    .ctlRdData(ctlRdData), .stb(stb),
    .headValid(headValid), .headWrite(headWrite), .headHalf(headHalf),
    .wrHeadHalf(wrHeadHalf), .tagHeadHalf(tagHeadHalf),
    .wrCount(wrCount), .tagCount(tagCount), .rdLevel(rdLevel), .rdFull(rdFull)
  );

  bridgeControl #(.RD_AW(RD_AW), .OUT_AW(OUT_AW)) u_control (
    .ctlClk(ctlClk), .ctlRstN(ctlRstN), .ctlReady(ctlReady), .ctlGetData(ctlGetData),
    .ctlDataValid(ctlDataValid), .headValid(headValid), .headWrite(headWrite),
    .headHalf(headHalf), .wrHeadHalf(wrHeadHalf), .tagHeadHalf(tagHeadHalf),
    .wrCount(wrCount), .tagCount(tagCount), .rdLevel(rdLevel), .rdFull(rdFull),
    .ctlRead(ctlRead), .ctlWrite(ctlWrite), .stb(stb)
  );

endmodule

// File: tb/test_memCmdBridge.sv
`timescale 1ns/1ps
module test_memCmdBridge;

  typedef struct {
    bit         wr;
    bit         half;
    bit [31:0]  addr;
    bit [31:0]  tag;
    bit [143:0] d0;
    bit [143:0] d1;
    bit [17:0]  m0;
    bit [17:0]  m1;
  } cmd_t;

  logic usrClk = 0, ctlClk = 0, usrRstN = 0, ctlRstN = 0;
  logic usrCmdValid = 0, usrCmdWrite = 0, usrCmdHalf = 0;
  logic [31:0]  usrCmdAddr = '0, usrCmdTag = '0;
  logic [287:0] usrWrData = '0;
  logic [35:0]  usrWrMask = '0;
  logic usrCmdAck, usrRdValid, usrRdAck = 0;
  logic [143:0] usrRdData;
  logic [31:0]  usrRdTag;
  logic ctlReady = 0, ctlRead, ctlWrite, ctlHalf, ctlGetData = 0, ctlDataValid = 0;
  logic [31:0]  ctlAddr;
  logic [143:0] ctlWrData, ctlRdData = '0;
  logic [17:0]  ctlWrMask;

  always #4   usrClk = ~usrClk;
  always #2.5 ctlClk = ~ctlClk;

  memCmdBridge i_memCmdBridge (
    .usrClk(usrClk), .usrRstN(usrRstN), .ctlClk(ctlClk), .ctlRstN(ctlRstN),
    .usrCmdValid(usrCmdValid), .usrCmdWrite(usrCmdWrite), .usrCmdHalf(usrCmdHalf),
    .usrCmdAddr(usrCmdAddr), .usrCmdTag(usrCmdTag), .usrWrData(usrWrData),
    .usrWrMask(usrWrMask), .usrCmdAck(usrCmdAck), .usrRdValid(usrRdValid),
    .usrRdData(usrRdData), .usrRdTag(usrRdTag), .usrRdAck(usrRdAck),
    .ctlReady(ctlReady), .ctlRead(ctlRead), .ctlWrite(ctlWrite), .ctlHalf(ctlHalf),
    .ctlAddr(ctlAddr), .ctlGetData(ctlGetData), .ctlWrData(ctlWrData),
    .ctlWrMask(ctlWrMask), .ctlDataValid(ctlDataValid), .ctlRdData(ctlRdData)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  cmd_t cmdQ[$];
  cmd_t phaseQ[$];
  logic [175:0] rdExp[$];
  bit ctlHold = 0, rdAckEn = 1, act = 0;
  int gap = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] actV, input logic [191:0] expV);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, actV, expV);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  function automatic logic [143:0] rdPat(input logic [31:0] a, input int b);
    logic [31:0] bb;
    bb = 32'(b);
    return {16'h5A00 + bb[15:0], a, ~a, a * 32'd3 + bb, 32'hC0DE0000 + bb};
  endfunction

  function automatic cmd_t mkCmd(input bit wr, input bit half, input logic [31:0] addr);
    cmd_t c;
    c.wr = wr; c.half = half; c.addr = addr; c.tag = $urandom;
    c.d0 = {16'($urandom), $urandom, $urandom, $urandom, $urandom};
    c.d1 = {16'($urandom), $urandom, $urandom, $urandom, $urandom};
    c.m0 = 18'($urandom); c.m1 = 18'($urandom);
    return c;
  endfunction

  task automatic drive(input cmd_t c);
    usrCmdValid = 1; usrCmdWrite = c.wr; usrCmdHalf = c.half;
    usrCmdAddr = c.addr; usrCmdTag = c.tag;
    usrWrData = {c.d1, c.d0}; usrWrMask = {c.m1, c.m0};
  endtask

  task automatic record(input cmd_t c);
    cmdQ.push_back(c);
    if (!c.wr)
      for (int b = 0; b < (c.half ? 1 : 2); b++)
        rdExp.push_back({rdPat({c.addr[31:4], 4'h0}, b), c.tag});
  endtask

  // hold valid until acknowledged
  task automatic sendCmd(input cmd_t c);
    @(negedge usrClk);
    drive(c);
    #1;
    while (!usrCmdAck) begin @(negedge usrClk); #1; end
    record(c);
    @(posedge usrClk);
  endtask

  // hold valid for a bounded time, report acceptance
  task automatic tryCmd(input cmd_t c, input int limit, output bit taken);
    taken = 0;
    @(negedge usrClk);
    drive(c);
    for (int i = 0; i < limit && !taken; i++) begin
      #1;
      if (usrCmdAck) taken = 1; else @(negedge usrClk);
    end
    if (taken) begin record(c); @(posedge usrClk); end
  endtask

  task automatic idle();
    @(negedge usrClk);
    usrCmdValid = 0;
  endtask

  // behavioural controller model
  initial begin : ctlModel
    cmd_t cur, e;
    int beat = 0, dly = 0;
    bit doBeat;
    wait (ctlRstN);
    forever begin
      @(negedge ctlClk);
      ctlGetData = 0; ctlDataValid = 0; doBeat = 0;
      if (gap > 0) begin ctlReady = 0; gap--; end
      else ctlReady = !ctlHold;
      if (!act && phaseQ.size() > 0) begin
        cur = phaseQ.pop_front(); act = 1; beat = 0; dly = 1 + int'($urandom % 3);
      end else if (act) begin
        if (dly > 0) dly--;
        else begin
          doBeat = 1;
          if (cur.wr) ctlGetData = 1;
          else begin ctlDataValid = 1; ctlRdData = rdPat({cur.addr[31:4], 4'h0}, beat); end
        end
      end
      #1;
      if (doBeat) begin
        if (cur.wr)
          chk({ctlWrData, ctlWrMask} == (beat == 0 ? {cur.d0, cur.m0} : {cur.d1, cur.m1}),
              "R5", "write beat", 192'({ctlWrData, ctlWrMask}),
              192'(beat == 0 ? {cur.d0, cur.m0} : {cur.d1, cur.m1}));
        beat++;
        if (beat == (cur.half ? 1 : 2)) act = 0;
      end
      if (ctlRead || ctlWrite) begin
        chk(ctlReady && !(ctlRead && ctlWrite), "R3", "command without ready or both",
            192'({ctlReady, ctlRead, ctlWrite}), 192'(3'b110));
        if (ctlReady) begin
          if (cmdQ.size() == 0)
            chk(0, "R10", "issue with nothing accepted", 192'(1), 192'(0));
          else begin
            e = cmdQ.pop_front();
            chk(ctlWrite == e.wr && ctlHalf == e.half, "R2", "order/flags",
                192'({ctlWrite, ctlHalf}), 192'({e.wr, e.half}));
            chk(ctlAddr == {e.addr[31:4], 4'h0}, "R4", "aligned address",
                192'(ctlAddr), 192'({e.addr[31:4], 4'h0}));
            phaseQ.push_back(e);
          end
          gap = 1 + int'($urandom % 2);
        end
      end
    end
  end

  // user read consumer
  initial begin : rdSide
    logic [175:0] x;
    wait (usrRstN);
    forever begin
      @(negedge usrClk);
      usrRdAck = 0;
      if (rdAckEn && usrRdValid && ($urandom % 4 != 0)) begin
        if (rdExp.size() == 0) chk(0, "R6", "unexpected beat", 192'({usrRdData, usrRdTag}), 192'(0));
        else begin
          x = rdExp.pop_front();
          chk({usrRdData, usrRdTag} == x, "R6", "read beat and tag",
              192'({usrRdData, usrRdTag}), 192'(x));
        end
        usrRdAck = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge usrClk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin : mainSeq
    bit taken;
    int acc;
    logic [175:0] held;
    #101;
    usrRstN = 1; ctlRstN = 1;
    @(negedge usrClk); #1;
    // R9 reset state
    chk(!usrRdValid, "R9", "rd valid after reset", 192'(usrRdValid), 192'(0));
    chk(!ctlRead && !ctlWrite, "R9", "no command after reset", 192'({ctlRead, ctlWrite}), 192'(0));
    chk(!usrCmdAck, "R9", "no ack without valid", 192'(usrCmdAck), 192'(0));

    // directed: same-cycle acknowledge on an idle bridge (R1), half/full beats (R5, R6)
    repeat (4) @(negedge usrClk);
    drive(mkCmd(1, 1, 32'h0000_100F)); #1;
    chk(usrCmdAck, "R1", "ack in first valid cycle", 192'(usrCmdAck), 192'(1));
    record(mkCmd(1, 1, 32'h0000_100F));
    cmdQ.pop_back();
    begin
      cmd_t c;
      c = mkCmd(1, 1, 32'h0000_100F);
      drive(c); #0;
      record(c);
    end
    @(posedge usrClk);
    sendCmd(mkCmd(1, 0, 32'h0000_2007));
    sendCmd(mkCmd(0, 1, 32'h0000_300A));
    sendCmd(mkCmd(0, 0, 32'h0000_4005));
    idle();

    // mixed random traffic
    for (int i = 0; i < 40; i++)
      sendCmd(mkCmd(1'($urandom), 1'($urandom), $urandom));
    idle();
    wait (cmdQ.size() == 0 && phaseQ.size() == 0 && !act);
    repeat (10) @(negedge usrClk);

    // R1: controller stalled, queue fills to its depth
    ctlHold = 1;
    repeat (6) @(negedge usrClk);
    acc = 0;
    for (int i = 0; i < 12; i++) begin
      tryCmd(mkCmd(1, 1'($urandom), $urandom), 6, taken);
      if (taken) acc++;
    end
    idle();
    chk(acc == 8, "R1", "accepted before full", 192'(acc), 192'(8));
    ctlHold = 0;
    wait (cmdQ.size() == 0 && phaseQ.size() == 0 && !act);

    // R8: user stops popping, return beats exceed the queue
    rdAckEn = 0;
    for (int i = 0; i < 12; i++) sendCmd(mkCmd(0, 0, $urandom));
    idle();
    repeat (400) @(negedge usrClk);
    chk(usrRdValid, "R7", "beat held without ack", 192'(usrRdValid), 192'(1));
    held = {usrRdData, usrRdTag};
    repeat (5) @(negedge usrClk);
    chk({usrRdData, usrRdTag} == held, "R7", "held beat stable", 192'({usrRdData, usrRdTag}), 192'(held));
    chk(rdExp.size() == 24, "R8", "no beat consumed", 192'(rdExp.size()), 192'(24));
    rdAckEn = 1;

    wait (cmdQ.size() == 0 && phaseQ.size() == 0 && !act && rdExp.size() == 0);
    repeat (50) @(negedge usrClk);
    chk(!usrRdValid, "R8", "no extra beats", 192'(usrRdValid), 192'(0));
    chk(cmdQ.size() == 0, "R10", "all commands issued", 192'(cmdQ.size()), 192'(0));
    summary();
  end

endmodule